// File: doc/BRIEF.md
# Parallel Port Reverse-Channel Host Sequencer

This block is the host end of an IEEE 1284 ECP link for data that flows back from the peripheral. A read request that arrives while the link is in forward idle turns the bus around. The block pulls HostAck (nAutoFd) low with nStrobe held high and switches the data pins to input. After a programmable settle delay it pulls nInit low and waits for the peripheral to acknowledge the turnaround by lowering PError (nAckReverse). It then takes one byte with the four-step HostAck/nAck handshake and parks in reverse idle.

Each later read request taken in reverse idle collects one more byte and does not reverse the bus again. A terminate request sends the link back to forward idle. The data pins turn back to output only after the peripheral confirms by raising PError.

Every handshake wait has a programmable cycle limit. If a wait expires, a sticky error flag for that stage is set and the handshake lines are released high. The data pins are left as inputs, so the two ends never drive the bus at the same time. Both status inputs pass through two-flop synchronizers before the sequencer uses them.

Top module: `ecp_rev_host`

## Requirements
- R1: After reset nStrobe, HostAck and nInit are high, the data pins are outputs (`bus_in_o`=0), `phase_o` is 0 (forward idle), `rx_valid_o` is 0 and all three error flags are 0.
- R2: A read request in forward idle makes HostAck low, nStrobe high and `bus_in_o` 1 in the next cycle. nInit falls exactly `settle_cyc_i`+1 cycles after HostAck falls. `phase_o` reads 1 during the turnaround.
- R3: While nInit is low, PError low (seen through a two-cycle synchronizer) moves the block to `phase_o`=2 with HostAck still low. If PError stays high, then `tmo_cyc_i` cycles after nInit falls nothing has changed yet. One cycle later `err_rev_o` is 1, nInit and HostAck are high, `phase_o` is 0 and `bus_in_o` stays 1.
- R4: When nAck goes low in `phase_o`=2, the data pins are captured. `rx_valid_o` pulses for exactly one cycle with `rx_data_o` holding that byte, and HostAck rises in the same cycle.
- R5: When nAck returns high the block enters reverse idle (`phase_o`=3) with HostAck high. nAck activity in reverse idle produces no byte and leaves HostAck high.
- R6: A read request in reverse idle lowers HostAck in the next cycle and goes straight to `phase_o`=2. nInit stays low.
- R7: If nAck does not fall, or does not rise again, within `tmo_cyc_i`+1 cycles, `err_byte_o` is set, nInit and HostAck go high, `phase_o` becomes 0 and `bus_in_o` stays 1.
- R8: A terminate request in reverse idle raises nInit and HostAck in the next cycle and shows `phase_o`=4. `bus_in_o` returns to 0, together with `phase_o`=0, only after PError is seen high.
- R9: If PError stays low for `tmo_cyc_i`+1 cycles after a terminate, `err_fwd_o` is set, `phase_o` becomes 0 and `bus_in_o` stays 1.
- R10: A terminate in forward idle and a read request during a byte handshake have no effect. If terminate and read arrive together in reverse idle, terminate wins.
- R11: Error flags stay set through later successful transfers until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_start_i | input | 1 | Read one byte (reverses the bus first if needed) |
| term_i | input | 1 | Return the link to forward idle |
| settle_cyc_i | input | CNT_W | Settle delay between HostAck low and nInit low |
| tmo_cyc_i | input | CNT_W | Limit for every handshake wait |
| n_ack_i | input | 1 | Peripheral nAck status line |
| p_error_i | input | 1 | Peripheral PError / nAckReverse line |
| data_i | input | DATA_W | Data pins as seen by the host |
| n_strobe_o | output | 1 | nStrobe, held high |
| host_ack_o | output | 1 | nAutoFd / HostAck |
| n_init_o | output | 1 | nInit (reverse request) |
| bus_in_o | output | 1 | 1 = data pins are inputs |
| rx_data_o | output | DATA_W | Last captured byte |
| rx_valid_o | output | 1 | One-cycle strobe for a new byte |
| phase_o | output | 3 | 0 fwd idle, 1 turning to reverse, 2 byte handshake, 3 reverse idle, 4 turning to forward |
| err_rev_o | output | 1 | Sticky: reversal not acknowledged |
| err_byte_o | output | 1 | Sticky: byte handshake stalled |
| err_fwd_o | output | 1 | Sticky: return to forward not acknowledged |

## Verification
The hardest cases to reach are the timing edges: the exact cycle in which a timeout fires, and requests that arrive in a state that must ignore them. A peripheral that simply behaves never stalls, and it never pokes the host in the middle of a handshake. The stimulus therefore models a peripheral whose response delays are drawn from a seeded random source. Directed passes then make it deliberately silent at each of the four waits. They also inject read and terminate pulses into reverse idle, into forward idle and into the middle of a byte. The expected settle and timeout gaps are counted cycle by cycle from the programmed limits.

// File: rtl/ecp_rev_pkg.sv
package ecp_rev_pkg;

  typedef enum logic [2:0] {
    PH_FWD      = 3'd0,
    PH_TO_REV   = 3'd1,
    PH_XFER     = 3'd2,
    PH_REV_IDLE = 3'd3,
    PH_TO_FWD   = 3'd4
  } phase_e;

  typedef enum logic [2:0] {
    ST_FWD,    // forward idle, lines released
    ST_SETTLE, // HostAck low, bus turned, settle delay running
    ST_REVACK, // nInit low, waiting PError low
    ST_ACKLO,  // HostAck low, waiting nAck low
    ST_ACKHI,  // HostAck high, waiting nAck high
    ST_RIDLE,  // reverse idle, HostAck high
    ST_FWDACK  // nInit high, waiting PError high
  } state_e;

  function automatic phase_e phase_of(input state_e s);
    case (s)
      ST_SETTLE, ST_REVACK: phase_of = PH_TO_REV;
      ST_ACKLO, ST_ACKHI:   phase_of = PH_XFER;
      ST_RIDLE:             phase_of = PH_REV_IDLE;
      ST_FWDACK:            phase_of = PH_TO_FWD;
      default:              phase_of = PH_FWD;
    endcase
  endfunction

endpackage

// File: rtl/ecp_rev_sync.sv
module ecp_rev_sync #(
  parameter int               WIDTH   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[g];
        sync_q <= RST_VAL[g];
      end else begin
        meta_q <= d_i[g];
        sync_q <= meta_q;
      end
    end

    assign q_o[g] = sync_q;
  end

endmodule

// File: rtl/ecp_rev_timer.sv
module ecp_rev_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic [W-1:0] lim_i,
  output logic         hit_o
);

  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    if (clr_i)                cnt_d = '0;
    else if (cnt_q == CNT_MAX) cnt_d = cnt_q;
    else                      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hit_o = (cnt_q >= lim_i);

  // R3: the window counter saturates instead of wrapping back to zero
  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/ecp_rev_host.sv
module ecp_rev_host
  import ecp_rev_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_start_i,
  input  logic              term_i,
  input  logic [CNT_W-1:0]  settle_cyc_i,
  input  logic [CNT_W-1:0]  tmo_cyc_i,
  input  logic              n_ack_i,
  input  logic              p_error_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              n_strobe_o,
  output logic              host_ack_o,
  output logic              n_init_o,
  output logic              bus_in_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic [2:0]        phase_o,
  output logic              err_rev_o,
  output logic              err_byte_o,
  output logic              err_fwd_o
);

  localparam int NSTAT = 2;

  // reset: asserted asynchronously, released through two flops
  logic rst_q_n;
  ecp_rev_sync #(.WIDTH(1), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (1'b1),
    .q_o   (rst_q_n)
  );

  // status synchronizers, idle level high
  logic [NSTAT-1:0] stat_s;
  logic             nack_s;
  logic             perr_s;
  ecp_rev_sync #(.WIDTH(NSTAT), .RST_VAL({NSTAT{1'b1}})) u_stat_sync (
    .clk   (clk),
    .rst_n (rst_q_n),
    .d_i   ({n_ack_i, p_error_i}),
    .q_o   (stat_s)
  );
  assign nack_s = stat_s[1];
  assign perr_s = stat_s[0];

  state_e state_q, state_d;
  logic   autofd_q, autofd_d;
  logic   init_q, init_d;
  logic   busin_q, busin_d;
  logic   vld_q, vld_d;
  logic   erv_q, erv_d;
  logic   eby_q, eby_d;
  logic   efw_q, efw_d;
  logic   cap_en;
  logic   tmr_hit;
  logic   tmr_clr;
  logic [CNT_W-1:0]  tmr_lim;
  logic [DATA_W-1:0] rx_q;

  assign tmr_clr = (state_d != state_q);
  assign tmr_lim = (state_q == ST_SETTLE) ? settle_cyc_i : tmo_cyc_i;

  ecp_rev_timer #(.W(CNT_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_q_n),
    .clr_i (tmr_clr),
    .lim_i (tmr_lim),
    .hit_o (tmr_hit)
  );

  always_comb begin
    state_d  = state_q;
    autofd_d = autofd_q;
    init_d   = init_q;
    busin_d  = busin_q;
    erv_d    = erv_q;
    eby_d    = eby_q;
    efw_d    = efw_q;
    vld_d    = 1'b0;
    cap_en   = 1'b0;
    case (state_q)
      ST_FWD: begin
        if (rd_start_i) begin
          state_d  = ST_SETTLE;
          autofd_d = 1'b0;
          busin_d  = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (tmr_hit) begin
          state_d = ST_REVACK;
          init_d  = 1'b0;
        end
      end
      ST_REVACK: begin
        if (!perr_s) begin
          state_d = ST_ACKLO;
        end else if (tmr_hit) begin
          state_d  = ST_FWD;
          autofd_d = 1'b1;
          init_d   = 1'b1;
          erv_d    = 1'b1;
        end
      end
      ST_ACKLO: begin
        if (!nack_s) begin
          state_d  = ST_ACKHI;
          autofd_d = 1'b1;
          vld_d    = 1'b1;
          cap_en   = 1'b1;
        end else if (tmr_hit) begin
          state_d  = ST_FWD;
          autofd_d = 1'b1;
          init_d   = 1'b1;
          eby_d    = 1'b1;
        end
      end
      ST_ACKHI: begin
        if (nack_s) begin
          state_d = ST_RIDLE;
        end else if (tmr_hit) begin
          state_d  = ST_FWD;
          autofd_d = 1'b1;
          init_d   = 1'b1;
          eby_d    = 1'b1;
        end
      end
      ST_RIDLE: begin
        if (term_i) begin
          state_d  = ST_FWDACK;
          autofd_d = 1'b1;
          init_d   = 1'b1;
        end else if (rd_start_i) begin
          state_d  = ST_ACKLO;
          autofd_d = 1'b0;
        end
      end
      ST_FWDACK: begin
        if (perr_s) begin
          state_d = ST_FWD;
          busin_d = 1'b0;
        end else if (tmr_hit) begin
          state_d = ST_FWD;
          efw_d   = 1'b1;
        end
      end
      default: begin
        state_d  = ST_FWD;
        autofd_d = 1'b1;
        init_d   = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q  <= ST_FWD;
      autofd_q <= 1'b1;
      init_q   <= 1'b1;
      busin_q  <= 1'b0;
      vld_q    <= 1'b0;
      erv_q    <= 1'b0;
      eby_q    <= 1'b0;
      efw_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      autofd_q <= autofd_d;
      init_q   <= init_d;
      busin_q  <= busin_d;
      vld_q    <= vld_d;
      erv_q    <= erv_d;
      eby_q    <= eby_d;
      efw_q    <= efw_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    rx_q <= '0;
    else if (cap_en) rx_q <= data_i;
  end

  assign n_strobe_o = 1'b1;
  assign host_ack_o = autofd_q;
  assign n_init_o   = init_q;
  assign bus_in_o   = busin_q;
  assign rx_data_o  = rx_q;
  assign rx_valid_o = vld_q;
  assign phase_o    = phase_of(state_q);
  assign err_rev_o  = erv_q;
  assign err_byte_o = eby_q;
  assign err_fwd_o  = efw_q;

  // R2: nInit is only ever lowered while HostAck is already low
  p_init_after_ack_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    $fell(n_init_o) |-> !host_ack_o);

  // R4: a byte strobe always coincides with HostAck rising
  p_valid_ack_rise_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    rx_valid_o |-> $rose(host_ack_o));

  // R4: bytes are only reported while the data pins are inputs
  p_valid_bus_in_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    rx_valid_o |-> bus_in_o);

  // R6: a read in reverse idle re-arms HostAck without a new reversal
  p_skip_reverse_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (state_q == ST_RIDLE && rd_start_i && !term_i)
      |=> (!n_init_o && !host_ack_o && phase_o == PH_XFER));

  // R8: a terminate raises nInit and HostAck together
  p_term_release_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (state_q == ST_RIDLE && term_i) |=> (n_init_o && host_ack_o));

  // R8: the pins turn to output only after PError was seen high
  p_bus_out_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    $fell(bus_in_o) |-> $past(perr_s));

  // R11: error flags are sticky
  p_err_rev_sticky_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    err_rev_o |=> err_rev_o);
  p_err_byte_sticky_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    err_byte_o |=> err_byte_o);

endmodule

// File: tb/ecp_rev_host_bench.sv
module ecp_rev_host_bench;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rd_start_i, term_i;
  logic [CW-1:0] settle_cyc_i, tmo_cyc_i;
  logic          n_ack_i, p_error_i;
  logic [7:0]    data_i;
  logic          n_strobe_o, host_ack_o, n_init_o, bus_in_o;
  logic [7:0]    rx_data_o;
  logic          rx_valid_o;
  logic [2:0]    phase_o;
  logic          err_rev_o, err_byte_o, err_fwd_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  ecp_rev_host #(.CNT_W(CW), .DATA_W(8)) u_ecp_rev_host (
    .clk(clk), .rst_n(rst_n), .rd_start_i(rd_start_i), .term_i(term_i),
    .settle_cyc_i(settle_cyc_i), .tmo_cyc_i(tmo_cyc_i),
    .n_ack_i(n_ack_i), .p_error_i(p_error_i), .data_i(data_i),
    .n_strobe_o(n_strobe_o), .host_ack_o(host_ack_o), .n_init_o(n_init_o),
    .bus_in_o(bus_in_o), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o),
    .phase_o(phase_o), .err_rev_o(err_rev_o), .err_byte_o(err_byte_o),
    .err_fwd_o(err_fwd_o)
  );

  // expected gaps derived from the requirements
  function automatic int exp_settle_gap(input int s);
    return s + 1;
  endfunction
  function automatic int exp_quiet_steps(input int t);
    return t;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_phase(input int ph);
    for (int i = 0; i < 200 && phase_o != 3'(ph); i++) step();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rd_start_i = 1'b0; term_i = 1'b0;
    n_ack_i = 1'b1; p_error_i = 1'b1; data_i = 8'h00;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
  endtask

  task automatic pulse_rd();
    rd_start_i = 1'b1; step(); rd_start_i = 1'b0;
  endtask

  // from forward idle: reverse the bus (R2, R3)
  task automatic reverse_bus(input int settle, input int pdly);
    int gap;
    settle_cyc_i = CW'(settle);
    pulse_rd();
    chk("R2", "HostAck low", int'(host_ack_o), 0);
    chk("R2", "nStrobe high", int'(n_strobe_o), 1);
    chk("R2", "bus input", int'(bus_in_o), 1);
    chk("R2", "phase turning", int'(phase_o), 1);
    gap = 0;
    for (int i = 0; i < 100 && n_init_o; i++) begin step(); gap++; end
    chk("R2", "settle gap", gap, exp_settle_gap(settle));
    repeat (pdly) step();
    p_error_i = 1'b0;
    wait_phase(2);
    chk("R3", "phase xfer", int'(phase_o), 2);
    chk("R3", "HostAck low in xfer", int'(host_ack_o), 0);
  endtask

  // one byte handshake from phase 2 (R4, R5, R10)
  task automatic xfer_byte(input logic [7:0] b, input int d1, input int d2, input bit poke);
    data_i = b;
    repeat (d1) step();
    n_ack_i = 1'b0;
    for (int i = 0; i < 100 && !host_ack_o; i++) step();
    chk("R4", "valid with HostAck rise", int'(rx_valid_o), 1);
    chk("R4", "byte value", int'(rx_data_o), int'(b));
    step();
    chk("R4", "valid single cycle", int'(rx_valid_o), 0);
    if (poke) pulse_rd();
    repeat (d2) step();
    n_ack_i = 1'b1;
    wait_phase(3);
    step(); step();
    chk("R5", "rev idle", int'(phase_o), 3);
    chk(poke ? "R10" : "R5", "HostAck held high", int'(host_ack_o), 1);
  endtask

  task automatic rev_read(input logic [7:0] b);
    pulse_rd();
    chk("R6", "phase xfer direct", int'(phase_o), 2);
    chk("R6", "HostAck low", int'(host_ack_o), 0);
    chk("R6", "nInit stays low", int'(n_init_o), 0);
    xfer_byte(b, 1 + int'($urandom_range(5)), int'($urandom_range(5)), 1'b0);
  endtask

  task automatic go_fwd(input int pdly);
    term_i = 1'b1; step(); term_i = 1'b0;
    chk("R8", "nInit high", int'(n_init_o), 1);
    chk("R8", "HostAck high", int'(host_ack_o), 1);
    chk("R8", "phase turning fwd", int'(phase_o), 4);
    repeat (pdly) step();
    chk("R8", "bus still input", int'(bus_in_o), 1);
    p_error_i = 1'b1;
    wait_phase(0);
    chk("R8", "bus output", int'(bus_in_o), 0);
  endtask

  initial begin
    int unsigned seed;
    int t;
    seed = $urandom(32'd7741);
    settle_cyc_i = '0;
    tmo_cyc_i    = CW'(40);
    do_reset();

    // R1 reset state
    chk("R1", "nStrobe", int'(n_strobe_o), 1);
    chk("R1", "HostAck", int'(host_ack_o), 1);
    chk("R1", "nInit", int'(n_init_o), 1);
    chk("R1", "bus dir", int'(bus_in_o), 0);
    chk("R1", "phase", int'(phase_o), 0);
    chk("R1", "valid", int'(rx_valid_o), 0);
    chk("R1", "errors", int'({err_rev_o, err_byte_o, err_fwd_o}), 0);

    // R10 terminate in forward idle is ignored
    term_i = 1'b1; step(); term_i = 1'b0; step();
    chk("R10", "fwd term phase", int'(phase_o), 0);
    chk("R10", "fwd term lines", int'({host_ack_o, n_init_o, bus_in_o}), 6);

    // directed: zero settle
    reverse_bus(0, 0);
    xfer_byte(8'hA5, 0, 0, 1'b0);
    go_fwd(0);

    // random rounds
    for (int r = 0; r < 10; r++) begin
      reverse_bus(int'($urandom_range(15)), int'($urandom_range(8)));
      xfer_byte(8'($urandom), int'($urandom_range(6)), int'($urandom_range(6)), 1'b0);
      for (int k = 0; k < int'($urandom_range(3)); k++) rev_read(8'($urandom));
      go_fwd(int'($urandom_range(8)));
    end

    // R5 nAck activity in reverse idle; R10 read poked mid-handshake
    reverse_bus(2, 1);
    xfer_byte(8'h3C, 2, 3, 1'b1);
    n_ack_i = 1'b0;
    for (int i = 0; i < 6; i++) begin
      step();
      if (rx_valid_o || !host_ack_o) chk("R5", "idle nAck ignored", 1, 0);
    end
    n_ack_i = 1'b1; repeat (3) step();
    chk("R5", "idle still", int'(phase_o), 3);
    // R10 terminate beats read
    rd_start_i = 1'b1; term_i = 1'b1; step(); rd_start_i = 1'b0; term_i = 1'b0;
    chk("R10", "term wins", int'(phase_o), 4);
    p_error_i = 1'b1; wait_phase(0);
    chk("R10", "back fwd", int'(bus_in_o), 0);

    // R3 reversal timeout, exact window
    do_reset();
    t = 5 + int'($urandom_range(15));
    tmo_cyc_i = CW'(t);
    settle_cyc_i = CW'(3);
    pulse_rd();
    for (int i = 0; i < 100 && n_init_o; i++) step();
    repeat (exp_quiet_steps(t)) step();
    chk("R3", "no early timeout", int'({err_rev_o, n_init_o}), 0);
    step();
    chk("R3", "err_rev set", int'(err_rev_o), 1);
    chk("R3", "lines released", int'({host_ack_o, n_init_o}), 3);
    chk("R3", "phase fwd", int'(phase_o), 0);
    chk("R3", "bus kept input", int'(bus_in_o), 1);
    // R11 sticky through a good transfer
    tmo_cyc_i = CW'(40);
    reverse_bus(1, 2);
    xfer_byte(8'h5A, 1, 1, 1'b0);
    go_fwd(2);
    chk("R11", "err_rev sticky", int'(err_rev_o), 1);

    // R7 stall waiting for nAck low
    do_reset();
    reverse_bus(1, 1);
    wait_phase(0);
    chk("R7", "err_byte (no ack)", int'(err_byte_o), 1);
    chk("R7", "lines released", int'({host_ack_o, n_init_o}), 3);
    chk("R7", "bus kept input", int'(bus_in_o), 1);
    chk("R7", "err_rev clear", int'(err_rev_o), 0);

    // R7 stall waiting for nAck high
    do_reset();
    reverse_bus(1, 1);
    n_ack_i = 1'b0;
    for (int i = 0; i < 100 && !host_ack_o; i++) step();
    wait_phase(0);
    chk("R7", "err_byte (ack stuck)", int'(err_byte_o), 1);
    chk("R7", "phase fwd", int'(phase_o), 0);
    n_ack_i = 1'b1;

    // R9 forward return timeout
    do_reset();
    reverse_bus(0, 0);
    xfer_byte(8'hC3, 1, 1, 1'b0);
    term_i = 1'b1; step(); term_i = 1'b0;
    wait_phase(0);
    chk("R9", "err_fwd", int'(err_fwd_o), 1);
    chk("R9", "bus kept input", int'(bus_in_o), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule